// File: doc/BRIEF.md
# Interrupt Vector Substitution Unit

This unit sits beside a small processor core and decides where the core goes after it takes an interrupt. The core has five fixed interrupt slots. When it fetches one of them, the unit supplies the 16-bit target address of a jump. In basic mode every slot is sent to its own fixed address in the top page of program memory. In extended mode the two external interrupt slots are sent to the routine of the source that won arbitration. That routine address comes from a table of eight 16-bit service addresses, one per extended source.

Software reaches the table and a control byte through a byte-wide special-function register port. The control byte holds the mode bit. The interrupt side of the core presents an acknowledge that carries the slot being entered and the index of the winning extended source. It also provides the per-channel external enable bits and the two per-channel source masks. The unit answers one cycle later with the jump address and a one-cycle valid strobe. Both external channels read the same table.

Top module: `irq_vector_subst`

## Requirements
- R1: After reset the control byte at 0x9B reads 0x02, every table byte reads 0x00 and `jmp_valid` is 0.
- R2: Source index i (0..7) has its service address low byte at 0xA4 + 8*(i/2) + 2*(i%2) and its high byte one address above. A write updates the byte and a read returns it.
- R3: The control byte at 0x9B is fully writable and readable. Its bit 2 selects the mode: 0 is basic, 1 is extended.
- R4: A write to any address that is neither 0x9B nor a table byte changes no readable register. A read of such an address returns 0x00.
- R5: In basic mode, an acknowledge of slot k (0..4) gives the address 0xFF03 + 8*k.
- R6: In extended mode, an acknowledge of slot 0 (channel 0) or slot 2 (channel 1) gives the table entry of `ack_src`. This holds only when that channel's bit in `ext_en` is 1 and bit `ack_src` of that channel's mask is 1.
- R7: Both channels take their address from the same table entry for the same source index.
- R8: In extended mode, an external slot whose channel enable is 0, or whose mask bit for the source is 0, gives the basic address of that slot. Only the mask of the acknowledged channel is consulted.
- R9: In extended mode, slots 1, 3 and 4 still give their basic addresses.
- R10: `jmp_valid` is 1 exactly in the cycle after an acknowledge with slot 0..4, and `jmp_addr` changes in that same cycle. An acknowledge with slot 5..7 raises no strobe. An acknowledge that coincides with a table write uses the value from before the write.
- R11: `jmp_addr` holds its value in every cycle that does not follow an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Register port address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rd | input | 1 | Read enable; read data is 0 while low |
| sfr_rdata | output | 8 | Read data, combinational from address |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_slot | input | 3 | Fixed slot being entered (0 ext0, 1, 2 ext1, 3, 4) |
| ack_src | input | 3 | Winning extended source index, 0 highest priority |
| ext_en | input | 2 | External interrupt enable per channel |
| mask_ch0 | input | 8 | Source mask of channel 0, bit i enables source i |
| mask_ch1 | input | 8 | Source mask of channel 1 |
| jmp_addr | output | 16 | Registered jump target |
| jmp_valid | output | 1 | One-cycle strobe for a new jump target |

## Verification
The bench targets the address map first. It writes a distinct value to every byte and checks that the unmapped holes between table pairs, such as 0xA8, read zero. A wrong address formula would alias two sources or leak a write into a hole. It also drives acknowledges where only the other channel's mask has the source bit set. A design that mixed up channel and mask would then jump into the table when it should fall back to the fixed address. The last case writes a table byte in the same cycle as an acknowledge. A design that forwarded the new value would produce the new address one acknowledge too early.

// File: rtl/vsu_pkg.sv
// Package: shared constants, address arithmetic and types of the vector
// substitution unit. Assumes an 8-bit register port and 16-bit addresses.
package vsu_pkg;
    localparam int DATA_W  = 8;
    localparam int VEC_W   = 16;
    localparam int N_SRC   = 8;
    localparam int SRC_W   = $clog2(N_SRC);
    localparam int SLOT_W  = 3;
    localparam int N_SLOT  = 5;
    localparam int BYTES_PER_VEC = VEC_W / DATA_W;

    localparam logic [7:0] CTRL_ADDR  = 8'h9B;
    localparam logic [7:0] CTRL_RESET = 8'h02;
    localparam int         MODE_BIT   = 2;
    localparam logic [7:0] TABLE_BASE = 8'hA4;
    localparam logic [7:0] FIXED_PAGE = 8'hFF;
    localparam logic [SLOT_W-1:0] SLOT_EXT0 = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_EXT1 = 3'd2;

    // Low-byte address of source i: pairs of entries per 8-byte group.
    function automatic logic [7:0] vec_lo_addr(input int i);
        vec_lo_addr = TABLE_BASE + 8'((i / 2) * 8 + (i % 2) * 2);
    endfunction

    // Decoded table selection for one register access.
    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] idx;
        logic             hi;
    } tbl_sel_t;
endpackage

// File: rtl/vsu_sfr_decode.sv
// Module: address decoder for the register port. Maps an address to the
// control byte or to one byte of one table entry. Purely combinational.
module vsu_sfr_decode
    import vsu_pkg::*;
#(
    parameter int NSRC = N_SRC
) (
    input  logic [7:0] addr,
    output logic       ctrl_hit,
    output tbl_sel_t   sel
);
    localparam int IW = $clog2(NSRC);

    logic [NSRC-1:0] lo_hit;
    logic [NSRC-1:0] hi_hit;

    // One comparator pair per table entry.
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign lo_hit[g] = (addr == vec_lo_addr(g));
        assign hi_hit[g] = (addr == vec_lo_addr(g) + 8'd1);
    end

    // Encode the one-hot hits into an entry index and a byte select.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (lo_hit[i] || hi_hit[i]) begin
                sel.hit = 1'b1;
                sel.idx = IW'(i);
                sel.hi  = hi_hit[i];
            end
        end
    end

    assign ctrl_hit = (addr == CTRL_ADDR);

    // The byte select must always come from an actual hit.
    always_comb begin
        a_r2_single_entry: assert ($onehot0({lo_hit, hi_hit}));
    end
endmodule

// File: rtl/vsu_ctrl_reg.sv
// Module: control byte holding the vectoring mode bit. Assumes the writer
// has already qualified the write with the address decode.
module vsu_ctrl_reg
    import vsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              ext_mode
);
    // Store the whole byte so software reads back what it wrote.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= CTRL_RESET;
        else if (wr_en) ctrl_q <= wdata;
    end

    assign ext_mode = ctrl_q[MODE_BIT];

    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/vsu_vec_table.sv
// Module: table of per-source service addresses, written a byte at a time.
// Presents every entry in parallel and the addressed byte for reads.
module vsu_vec_table
    import vsu_pkg::*;
#(
    parameter int NSRC = N_SRC,
    parameter int VW   = VEC_W,
    parameter int DW   = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  tbl_sel_t         sel,
    input  logic [DW-1:0]    wdata,
    output logic [NSRC*VW-1:0] vec_flat,
    output logic [DW-1:0]    rd_byte
);
    localparam int NB = VW / DW;

    // One register per byte of each entry.
    for (genvar e = 0; e < NSRC; e++) begin : g_ent
        for (genvar b = 0; b < NB; b++) begin : g_byte
            logic [DW-1:0] q;
            // Update this byte when the decode selects it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && sel.idx == e[SRC_W-1:0] && int'(sel.hi) == b)
                    q <= wdata;
            end
            assign vec_flat[e*VW + b*DW +: DW] = q;
        end
    end

    // Read the selected byte of the selected entry.
    always_comb begin
        rd_byte = vec_flat[int'(sel.idx)*VW + int'(sel.hi)*DW +: DW];
    end

    a_r4_table_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vec_flat));
endmodule

// File: rtl/vsu_jump_select.sv
// Module: picks and registers the jump target for an acknowledged slot.
// Assumes ack_src is the arbitration winner for the acknowledged channel.
module vsu_jump_select
    import vsu_pkg::*;
#(
    parameter int NSRC = N_SRC,
    parameter int VW   = VEC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_mode,
    input  logic                ack_valid,
    input  logic [SLOT_W-1:0]   ack_slot,
    input  logic [SRC_W-1:0]    ack_src,
    input  logic [1:0]          ext_en,
    input  logic [NSRC-1:0]     mask_ch0,
    input  logic [NSRC-1:0]     mask_ch1,
    input  logic [NSRC*VW-1:0]  vec_flat,
    output logic [VW-1:0]       jmp_addr,
    output logic                jmp_valid
);
    logic          slot_ok;
    logic          is_ext;
    logic          chan;
    logic          mask_bit;
    logic          take_ext;
    logic          accept;
    logic [VW-1:0] basic_addr;
    logic [VW-1:0] entry;

    // Classify the acknowledge and choose between table and fixed page.
    always_comb begin
        slot_ok    = (int'(ack_slot) < N_SLOT);
        is_ext     = (ack_slot == SLOT_EXT0) || (ack_slot == SLOT_EXT1);
        chan       = (ack_slot == SLOT_EXT1);
        mask_bit   = chan ? mask_ch1[ack_src] : mask_ch0[ack_src];
        take_ext   = ext_mode && is_ext && ext_en[chan] && mask_bit;
        accept     = ack_valid && slot_ok;
        basic_addr = {FIXED_PAGE, 2'b00, ack_slot, 3'b011};
        entry      = vec_flat[int'(ack_src)*VW +: VW];
    end

    // Register the target so it appears one cycle after the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jmp_addr  <= '0;
            jmp_valid <= 1'b0;
        end else begin
            jmp_valid <= accept;
            if (accept) jmp_addr <= take_ext ? entry : basic_addr;
        end
    end

    a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> jmp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !jmp_valid);
    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(jmp_addr));
    a_r6_table_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && take_ext) |=> jmp_addr == $past(entry));
    a_r9_fixed_page: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_ext) |=> jmp_addr[VW-1:8] == FIXED_PAGE);
endmodule

// File: rtl/irq_vector_subst.sv
// Module: top of the interrupt vector substitution unit. Joins the register
// port decode, control byte, vector table and jump selection.
module irq_vector_subst
    import vsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  sfr_addr,
    input  logic        sfr_wr,
    input  logic [7:0]  sfr_wdata,
    input  logic        sfr_rd,
    output logic [7:0]  sfr_rdata,
    input  logic        ack_valid,
    input  logic [2:0]  ack_slot,
    input  logic [2:0]  ack_src,
    input  logic [1:0]  ext_en,
    input  logic [7:0]  mask_ch0,
    input  logic [7:0]  mask_ch1,
    output logic [15:0] jmp_addr,
    output logic        jmp_valid
);
    logic                  ctrl_hit;
    tbl_sel_t              sel;
    logic [DATA_W-1:0]     ctrl_q;
    logic                  ext_mode;
    logic [N_SRC*VEC_W-1:0] vec_flat;
    logic [DATA_W-1:0]     tbl_byte;

    vsu_sfr_decode #(.NSRC(N_SRC)) u_dec (
        .addr     (sfr_addr),
        .ctrl_hit (ctrl_hit),
        .sel      (sel)
    );

    vsu_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sfr_wr && ctrl_hit),
        .wdata    (sfr_wdata),
        .ctrl_q   (ctrl_q),
        .ext_mode (ext_mode)
    );

    vsu_vec_table #(.NSRC(N_SRC), .VW(VEC_W), .DW(DATA_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sfr_wr && sel.hit),
        .sel      (sel),
        .wdata    (sfr_wdata),
        .vec_flat (vec_flat),
        .rd_byte  (tbl_byte)
    );

    vsu_jump_select #(.NSRC(N_SRC), .VW(VEC_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .ack_valid (ack_valid),
        .ack_slot  (ack_slot),
        .ack_src   (ack_src),
        .ext_en    (ext_en),
        .mask_ch0  (mask_ch0),
        .mask_ch1  (mask_ch1),
        .vec_flat  (vec_flat),
        .jmp_addr  (jmp_addr),
        .jmp_valid (jmp_valid)
    );

    // Read mux: control byte, table byte, or zero for unmapped addresses.
    always_comb begin
        if (!sfr_rd)       sfr_rdata = '0;
        else if (ctrl_hit) sfr_rdata = ctrl_q;
        else if (sel.hit)  sfr_rdata = tbl_byte;
        else               sfr_rdata = '0;
    end

    always_comb begin
        a_r4_unmapped_zero: assert (!(sfr_rd && !ctrl_hit && !sel.hit) || sfr_rdata == 8'h00);
    end
endmodule

// File: tb/irq_vector_subst_test.sv
module irq_vector_subst_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic        sfr_rd = 1'b0;
    logic [7:0]  sfr_rdata;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_slot = '0;
    logic [2:0]  ack_src = '0;
    logic [1:0]  ext_en = '0;
    logic [7:0]  mask_ch0 = '0;
    logic [7:0]  mask_ch1 = '0;
    logic [15:0] jmp_addr;
    logic        jmp_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_vector_subst uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic       mode;
        logic [2:0] slot;
        logic [2:0] src;
        logic [1:0] en;
        logic [7:0] m0;
        logic [7:0] m1;
        logic [15:0] exp;
    } vrow_t;

    localparam int NROWS = 16;
    localparam vrow_t ROWS [NROWS] = '{
        '{1'b0, 3'd0, 3'd0, 2'b11, 8'hFF, 8'hFF, 16'hFF03}, // R5
        '{1'b0, 3'd1, 3'd0, 2'b11, 8'hFF, 8'hFF, 16'hFF0B}, // R5
        '{1'b0, 3'd2, 3'd5, 2'b11, 8'hFF, 8'hFF, 16'hFF13}, // R5
        '{1'b0, 3'd3, 3'd0, 2'b11, 8'hFF, 8'hFF, 16'hFF1B}, // R5
        '{1'b0, 3'd4, 3'd0, 2'b11, 8'hFF, 8'hFF, 16'hFF23}, // R5
        '{1'b1, 3'd0, 3'd0, 2'b11, 8'h01, 8'h00, 16'hA000}, // R6
        '{1'b1, 3'd0, 3'd7, 2'b01, 8'h80, 8'h00, 16'hA777}, // R6
        '{1'b1, 3'd2, 3'd3, 2'b10, 8'h00, 8'h08, 16'hA333}, // R6
        '{1'b1, 3'd2, 3'd6, 2'b11, 8'h00, 8'h40, 16'hA666}, // R6
        '{1'b1, 3'd0, 3'd5, 2'b01, 8'h20, 8'h00, 16'hA555}, // R7
        '{1'b1, 3'd2, 3'd5, 2'b10, 8'h00, 8'h20, 16'hA555}, // R7
        '{1'b1, 3'd0, 3'd4, 2'b10, 8'hFF, 8'hFF, 16'hFF03}, // R8
        '{1'b1, 3'd0, 3'd4, 2'b11, 8'hEF, 8'h10, 16'hFF03}, // R8
        '{1'b1, 3'd2, 3'd1, 2'b11, 8'h02, 8'h00, 16'hFF13}, // R8
        '{1'b1, 3'd1, 3'd2, 2'b11, 8'hFF, 8'hFF, 16'hFF0B}, // R9
        '{1'b1, 3'd4, 3'd2, 2'b11, 8'hFF, 8'hFF, 16'hFF23}  // R9
    };

    function automatic logic [7:0] lo_addr(input int i);
        return 8'hA4 + 8'((i / 2) * 8 + (i % 2) * 2);
    endfunction

    function automatic logic [15:0] pattern(input int i);
        return 16'hA000 + 16'(i * 16'h0111);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_rd = 1'b1;
        #1 d = sfr_rdata;
        sfr_rd = 1'b0;
    endtask

    // Acknowledge, then check strobe, target, and that both hold after.
    task automatic do_ack(input string req, input logic [2:0] slot, input logic [2:0] src,
                          input logic [15:0] exp);
        @(negedge clk);
        ack_valid = 1'b1; ack_slot = slot; ack_src = src;
        @(negedge clk);
        ack_valid = 1'b0;
        check({req, " strobe"}, 16'(jmp_valid), 16'd1);
        check(req, jmp_addr, exp);
        @(negedge clk);
        check("R10 strobe drop", 16'(jmp_valid), 16'd0);
        check("R11 hold", jmp_addr, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        sfr_read(8'h9B, rd); check("R1 ctrl reset", 16'(rd), 16'h0002);
        for (int i = 0; i < 8; i++) begin
            sfr_read(lo_addr(i), rd);        check("R1 table lo reset", 16'(rd), 16'h0000);
            sfr_read(lo_addr(i) + 8'd1, rd); check("R1 table hi reset", 16'(rd), 16'h0000);
        end
        check("R1 valid reset", 16'(jmp_valid), 16'd0);

        // R2: program and read back every entry
        for (int i = 0; i < 8; i++) begin
            sfr_write(lo_addr(i), pattern(i)[7:0]);
            sfr_write(lo_addr(i) + 8'd1, pattern(i)[15:8]);
        end
        for (int i = 0; i < 8; i++) begin
            sfr_read(lo_addr(i), rd);        check("R2 lo readback", 16'(rd), 16'(pattern(i)[7:0]));
            sfr_read(lo_addr(i) + 8'd1, rd); check("R2 hi readback", 16'(rd), 16'(pattern(i)[15:8]));
        end

        // R3: control byte full readback
        sfr_write(8'h9B, 8'hF4);
        sfr_read(8'h9B, rd); check("R3 ctrl readback", 16'(rd), 16'h00F4);

        // R4: unmapped writes ignored, reads zero
        sfr_write(8'hA8, 8'h5A);
        sfr_write(8'h9C, 8'h5A);
        sfr_write(8'hC0, 8'h5A);
        sfr_read(8'hA8, rd); check("R4 hole read", 16'(rd), 16'h0000);
        sfr_read(8'h9C, rd); check("R4 unmapped read", 16'(rd), 16'h0000);
        sfr_read(8'hA7, rd); check("R4 neighbour intact", 16'(rd), 16'h00A1);
        sfr_read(8'hAC, rd); check("R4 neighbour intact", 16'(rd), 16'h0022);
        sfr_read(8'h9B, rd); check("R4 ctrl intact", 16'(rd), 16'h00F4);

        // R5..R9: table-driven acknowledges
        for (int r = 0; r < NROWS; r++) begin
            sfr_write(8'h9B, ROWS[r].mode ? 8'h04 : 8'h00);
            @(negedge clk);
            ext_en = ROWS[r].en; mask_ch0 = ROWS[r].m0; mask_ch1 = ROWS[r].m1;
            do_ack($sformatf("row%0d R5-9 vector", r), ROWS[r].slot, ROWS[r].src, ROWS[r].exp);
        end

        // R3: mode bit alone selects, other bits ignored
        sfr_write(8'h9B, 8'hFB);
        ext_en = 2'b11; mask_ch0 = 8'hFF;
        do_ack("R3 mode bit clear", 3'd0, 3'd1, 16'hFF03);

        // R10: slot out of range raises no strobe
        sfr_write(8'h9B, 8'h04);
        @(negedge clk);
        ack_valid = 1'b1; ack_slot = 3'd6; ack_src = 3'd0;
        @(negedge clk);
        ack_valid = 1'b0;
        check("R10 bad slot no strobe", 16'(jmp_valid), 16'd0);
        check("R11 bad slot hold", jmp_addr, 16'hFF03);

        // R10: write and acknowledge in the same cycle uses old entry
        @(negedge clk);
        sfr_addr = 8'hA4; sfr_wdata = 8'h55; sfr_wr = 1'b1;
        ack_valid = 1'b1; ack_slot = 3'd0; ack_src = 3'd0;
        @(negedge clk);
        sfr_wr = 1'b0; ack_valid = 1'b0;
        check("R10 same-cycle old value", jmp_addr, 16'hA000);
        do_ack("R10 new value next ack", 3'd0, 3'd0, 16'hA055);

        // R1: reset mid-run clears strobe and restores control byte
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        sfr_read(8'h9B, rd); check("R1 ctrl after reset", 16'(rd), 16'h0002);
        sfr_read(8'hBF, rd); check("R1 table after reset", 16'(rd), 16'h0000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule